// File: doc/BRIEF.md
# Clause 22 MDIO Management Master

This block is a management-interface master that runs Clause 22 read and write frames to external PHY devices over an MDC clock line and a bidirectional MDIO data line. Software controls it through one 32-bit command/status word. A single write of that word carries the PHY address, register number, operation and, for a write, the 16-bit value, and it launches the frame at once. The busy flag in the same word stays set until the frame is over. A read frame returns its 16-bit result in the low half of that word and raises a read-valid flag.

MDC is made from the system clock by a divider whose half-period is `cfg_div + 1` system clocks. `cfg_div` is sampled when a command is accepted. The data line is driven as a tri-state pair (`mdio_out`, `mdio_oe`) and sampled through `mdio_in`. Outgoing bits change on the falling edge of MDC. Incoming bits are sampled on the rising edge.

The serializer is a five-state machine: IDLE, PREAMBLE, HEADER, TURNAROUND and PAYLOAD. Its transitions are:
- LAUNCH: IDLE to PREAMBLE, when a command is accepted.
- PRE_DONE: PREAMBLE to HEADER, after 32 bits.
- HDR_DONE: HEADER to TURNAROUND, after 14 bits.
- TA_DONE: TURNAROUND to PAYLOAD, after 2 bits.
- FRAME_END: PAYLOAD back to IDLE, after 16 bits.

Every transition other than LAUNCH happens on an MDC falling edge.

Top module: `mdio_c22_master`

## Requirements
- R1: After reset, the status word reads all zeros, MDC is low and `mdio_oe` is low.
- R2: The status word is laid out as follows. The data field is bits [15:0]. The PHY address is bits [20:16]. The register number is bits [25:21]. The operation is bit 26, where 1 means read and 0 means write. Read-valid is bit 27 and busy is bit 28. Bits [31:29] read as zero. After an accepted command, bits [26:0] read back the written fields.
- R3: A command write while busy is clear is accepted. Busy reads 1 from the next cycle and stays set for exactly 128*(D+1) system cycles, where D is the divider value sampled at acceptance.
- R4: MDC is low while idle. During a frame it has a half-period of D+1 system cycles, and its first rising edge comes D+1 cycles after acceptance.
- R5: Every frame sends bits most significant first, in this order: 32 ones, start code 01, opcode (10 for read, 01 for write), the 5-bit PHY address, and the 5-bit register number. Each new bit appears together with an MDC falling edge; the first bit appears at acceptance.
- R6: A write frame drives turnaround 10 and then the 16 data bits, MSB first. It keeps `mdio_oe` high for all 64 bits and releases it when the frame ends.
- R7: A read frame releases `mdio_oe` for the turnaround and data bits (frame bits 46 to 63). It samples `mdio_in` on the rising MDC edge of each data bit. When busy clears, the 16 bits are in the data field, first-received bit in bit 15.
- R8: Read-valid becomes 1 in the same cycle that busy clears after a read frame, and never after a write frame. It returns to 0 when a new command is accepted.
- R9: A command write while busy is set has no effect on the fields, the frame or its length. This includes a write in the last busy cycle. A write held into the first idle cycle is accepted.
- R10: A change of `cfg_div` during a frame does not alter that frame's MDC period or length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_div | input | DIV_W | MDC half-period minus one, in system clocks |
| reg_wr_en | input | 1 | Command word write strobe |
| reg_wdata | input | 27 | Writable command fields (bits [26:0] of the word) |
| reg_rdata | output | 32 | Command/status word readback |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_in | input | 1 | Data line input value |

## Verification
Two events can fall in the same clock edge: a command write from software, and the MDC falling edge that ends a frame. At that edge busy is still set, so the write must be discarded. Held for one more cycle, the same write must start a fresh frame. The bench provokes this by raising the write strobe exactly in the last busy cycle of a frame and keeping it high one cycle longer. The behavioural model compares every output on every clock, and it expects the first strobe cycle to be ignored and the second to launch a frame carrying the new fields. A second overlap is a write landing in the middle of a read frame while `cfg_div` also changes. That read must still return its data and keep its original length.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRE,
        S_HDR,
        S_TA,
        S_DATA
    } mdio_state_e;

    localparam int ADDR_W   = 5;
    localparam int DATA_W   = 16;
    localparam int CMD_W    = 27;
    localparam int STAT_W   = 32;

    localparam int PRE_BITS = 32;
    localparam int HDR_BITS = 14;
    localparam int TA_BITS  = 2;
    localparam int CNT_W    = 5;

    localparam int F_DATA_LSB = 0;
    localparam int F_PHY_LSB  = 16;
    localparam int F_REG_LSB  = 21;
    localparam int F_OP_BIT   = 26;
    localparam int F_VLD_BIT  = 27;
    localparam int F_BSY_BIT  = 28;

    localparam logic [1:0] START_CODE = 2'b01;
    localparam logic [1:0] OPC_READ   = 2'b10;
    localparam logic [1:0] OPC_WRITE  = 2'b01;

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_m1,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);

    logic [DIV_W-1:0] cnt;
    logic             tick;

    always_comb begin
        tick      = run && (cnt == half_m1);
        rise_tick = tick && !mdc;
        fall_tick = tick && mdc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (!run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (tick) begin
            cnt <= '0;
            mdc <= !mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R4: clock line rests low whenever no frame runs
    assert_mdc_idle_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !mdc);

    // R4: a rising clock edge only follows a running cycle
    assert_mdc_rise_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> $past(run));

endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              is_read,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rise_tick,
    input  logic              fall_tick,
    input  logic              mdio_in,
    output logic              busy,
    output logic              frame_end,
    output logic [DATA_W-1:0] rd_data,
    output logic              mdio_out,
    output logic              mdio_oe
);

    mdio_state_e       state, state_nx;
    logic [CNT_W-1:0]  bitcnt;
    logic [CNT_W-1:0]  last_idx;
    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] cap;
    logic [DATA_W-1:0] hdr_word;
    logic              phase_last;

    always_comb begin
        hdr_word = {START_CODE, (is_read ? OPC_READ : OPC_WRITE), phy_addr, reg_addr, 2'b00};
    end

    always_comb begin
        unique case (state)
            S_PRE:   last_idx = CNT_W'(PRE_BITS - 1);
            S_HDR:   last_idx = CNT_W'(HDR_BITS - 1);
            S_TA:    last_idx = CNT_W'(TA_BITS - 1);
            S_DATA:  last_idx = CNT_W'(DATA_W - 1);
            default: last_idx = '0;
        endcase
        phase_last = fall_tick && (bitcnt == last_idx);
    end

    // next-state logic: named transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (go)         state_nx = S_PRE;   // LAUNCH
            S_PRE:   if (phase_last) state_nx = S_HDR;   // PRE_DONE
            S_HDR:   if (phase_last) state_nx = S_TA;    // HDR_DONE
            S_TA:    if (phase_last) state_nx = S_DATA;  // TA_DONE
            S_DATA:  if (phase_last) state_nx = S_IDLE;  // FRAME_END
            default: state_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // bit counter, transmit shifter and receive capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt <= '0;
            shreg  <= '0;
            cap    <= '0;
        end else begin
            if (state == S_IDLE && go) begin
                bitcnt <= '0;
            end else if (fall_tick) begin
                if (phase_last) begin
                    bitcnt <= '0;
                    if (state == S_PRE) shreg <= hdr_word;
                    if (state == S_TA)  shreg <= wr_data;
                end else begin
                    bitcnt <= bitcnt + 1'b1;
                    if (state == S_HDR || state == S_DATA)
                        shreg <= {shreg[DATA_W-2:0], 1'b0};
                end
            end
            if (rise_tick && state == S_DATA && is_read)
                cap <= {cap[DATA_W-2:0], mdio_in};
        end
    end

    // outputs
    always_comb begin
        busy      = (state != S_IDLE);
        frame_end = (state == S_DATA) && phase_last;
        rd_data   = cap;
        unique case (state)
            S_PRE:   begin mdio_oe = 1'b1;     mdio_out = 1'b1;                            end
            S_HDR:   begin mdio_oe = 1'b1;     mdio_out = shreg[DATA_W-1];                 end
            S_TA:    begin mdio_oe = !is_read; mdio_out = !is_read && (bitcnt == '0);      end
            S_DATA:  begin mdio_oe = !is_read; mdio_out = !is_read && shreg[DATA_W-1];     end
            default: begin mdio_oe = 1'b0;     mdio_out = 1'b0;                            end
        endcase
    end

    // checker: count falling edges inside a frame
    logic [6:0] falls_seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     falls_seen <= '0;
        else if (state == S_IDLE && go) falls_seen <= '0;
        else if (fall_tick)             falls_seen <= falls_seen + 1'b1;
    end

    // R3/R5: a frame spans 64 bit periods, so 63 falls precede the final one
    assert_frame_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> (falls_seen == 7'd63));

    // R5: after launch, phases only advance on a falling clock edge
    assert_step_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(state) != S_IDLE) && (state != $past(state))) |-> $past(fall_tick));

endmodule

// File: rtl/mdio_c22_master.sv
module mdio_c22_master
    import mdio_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              reg_wr_en,
    input  logic [CMD_W-1:0]  reg_wdata,
    output logic [STAT_W-1:0] reg_rdata,
    output logic              mdc,
    output logic              mdio_out,
    output logic              mdio_oe,
    input  logic              mdio_in
);

    logic              busy;
    logic              accept;
    logic              frame_end;
    logic              rise_tick;
    logic              fall_tick;
    logic [DATA_W-1:0] rd_data;

    logic [DATA_W-1:0] data_q;
    logic [ADDR_W-1:0] phy_q;
    logic [ADDR_W-1:0] reg_q;
    logic              rd_q;
    logic              valid_q;
    logic [DIV_W-1:0]  div_q;

    assign accept = reg_wr_en && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q  <= '0;
            phy_q   <= '0;
            reg_q   <= '0;
            rd_q    <= 1'b0;
            valid_q <= 1'b0;
            div_q   <= '0;
        end else if (accept) begin
            data_q  <= reg_wdata[F_DATA_LSB +: DATA_W];
            phy_q   <= reg_wdata[F_PHY_LSB +: ADDR_W];
            reg_q   <= reg_wdata[F_REG_LSB +: ADDR_W];
            rd_q    <= reg_wdata[F_OP_BIT];
            valid_q <= 1'b0;
            div_q   <= cfg_div;
        end else if (frame_end && rd_q) begin
            data_q  <= rd_data;
            valid_q <= 1'b1;
        end
    end

    always_comb begin
        reg_rdata = '0;
        reg_rdata[F_DATA_LSB +: DATA_W] = data_q;
        reg_rdata[F_PHY_LSB +: ADDR_W]  = phy_q;
        reg_rdata[F_REG_LSB +: ADDR_W]  = reg_q;
        reg_rdata[F_OP_BIT]             = rd_q;
        reg_rdata[F_VLD_BIT]            = valid_q;
        reg_rdata[F_BSY_BIT]            = busy;
    end

    mdio_mdc_gen #(.DIV_W(DIV_W)) u_mdc (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy),
        .half_m1   (div_q),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (accept),
        .is_read   (rd_q),
        .phy_addr  (phy_q),
        .reg_addr  (reg_q),
        .wr_data   (data_q),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_in   (mdio_in),
        .busy      (busy),
        .frame_end (frame_end),
        .rd_data   (rd_data),
        .mdio_out  (mdio_out),
        .mdio_oe   (mdio_oe)
    );

    // R9: a write during a frame leaves every command field untouched
    assert_busy_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && busy && !frame_end) |=> (reg_rdata[CMD_W-1:0] == $past(reg_rdata[CMD_W-1:0])));

    // R8: acceptance clears read-valid and raises busy
    assert_valid_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && !busy) |=> (!reg_rdata[F_VLD_BIT] && reg_rdata[F_BSY_BIT]));

    // R8: read-valid only appears as a read frame completes
    assert_valid_on_read_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_rdata[F_VLD_BIT]) |-> ($fell(reg_rdata[F_BSY_BIT]) && reg_rdata[F_OP_BIT]));

    // R10: the sampled divider holds for the whole frame
    assert_div_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(div_q));

endmodule

// File: tb/tb_mdio_c22_master.sv
module tb_mdio_c22_master;

    localparam int DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [DIV_W-1:0] drv_div = '0;
    logic             drv_wr = 1'b0;
    logic [26:0]      drv_wdata = '0;
    logic [31:0]      rdata;
    logic             mdc, mdio_out, mdio_oe;
    logic             mdio_in = 1'b1;

    always #5 clk = ~clk;

    mdio_c22_master #(.DIV_W(DIV_W)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_div   (drv_div),
        .reg_wr_en (drv_wr),
        .reg_wdata (drv_wdata),
        .reg_rdata (rdata),
        .mdc       (mdc),
        .mdio_out  (mdio_out),
        .mdio_oe   (mdio_oe),
        .mdio_in   (mdio_in)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    bit cmp_on = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference model
    bit          m_active = 0;
    int          m_t = 0;
    int          m_half = 1;
    bit          m_read = 0;
    logic [4:0]  m_phy = '0, m_reg = '0;
    logic [15:0] m_data = '0;
    bit          m_valid = 0;
    bit          m_bits [64];
    logic [15:0] phy_val = '0;

    function automatic logic [26:0] mk(input bit rd, input logic [4:0] phy,
                                       input logic [4:0] rg, input logic [15:0] d);
        return {rd, rg, phy, d};
    endfunction

    task automatic build_frame();
        int p = 0;
        for (int i = 0; i < 32; i++) m_bits[p++] = 1'b1;
        m_bits[p++] = 1'b0; m_bits[p++] = 1'b1;
        m_bits[p++] = m_read; m_bits[p++] = !m_read;
        for (int i = 4; i >= 0; i--) m_bits[p++] = m_phy[i];
        for (int i = 4; i >= 0; i--) m_bits[p++] = m_reg[i];
        m_bits[p++] = 1'b1; m_bits[p++] = 1'b0;
        for (int i = 15; i >= 0; i--) m_bits[p++] = m_data[i];
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_active = 0; m_t = 0; m_read = 0; m_phy = '0; m_reg = '0;
            m_data = '0; m_valid = 0;
        end else begin
            bit acc;
            acc = drv_wr && !m_active;
            if (m_active) begin
                m_t++;
                if (m_t == 128 * m_half) begin
                    m_active = 0;
                    if (m_read) begin m_data = phy_val; m_valid = 1; end
                end
            end
            if (acc) begin
                m_active = 1; m_t = 0; m_half = int'(drv_div) + 1;
                m_read = drv_wdata[26]; m_reg = drv_wdata[25:21];
                m_phy = drv_wdata[20:16]; m_data = drv_wdata[15:0]; m_valid = 0;
                build_frame();
            end
        end
    end

    // PHY model: answers read data bits, otherwise the line floats high
    always @(negedge clk) begin
        int k;
        k = m_t / (2 * m_half);
        if (m_active && m_read && k >= 48) mdio_in <= phy_val[63 - k];
        else                               mdio_in <= 1'b1;
    end

    // per-clock comparison
    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            int  k;
            bit  e_mdc, e_oe;
            k     = m_t / (2 * m_half);
            e_mdc = m_active && (((m_t / m_half) % 2) == 1);
            e_oe  = m_active && (!m_read || k < 46);
            chk("R3 busy flag", 32'(rdata[28]), 32'(m_active));
            chk("R4 mdc level", 32'(mdc), 32'(e_mdc));
            chk("R6/R7 output enable", 32'(mdio_oe), 32'(e_oe));
            if (e_oe) chk("R5 driven bit", 32'(mdio_out), 32'(m_bits[k]));
            chk("R8 read valid", 32'(rdata[27]), 32'(m_valid));
            chk("R2 fields", 32'(rdata[26:0]), 32'({m_read, m_reg, m_phy, m_data}));
            chk("R2 upper zero", 32'(rdata[31:29]), 32'd0);
        end
    end

    // busy length monitor
    int busy_cnt = 0;
    int last_len = 0;
    always @(negedge clk) begin
        if (rdata[28]) busy_cnt++;
        else if (busy_cnt != 0) begin last_len = busy_cnt; busy_cnt = 0; end
    end

    task automatic launch(input logic [26:0] w, input logic [DIV_W-1:0] d);
        @(negedge clk);
        drv_wr = 1'b1; drv_wdata = w; drv_div = d;
        @(negedge clk);
        drv_wr = 1'b0;
    endtask

    task automatic wait_idle();
        while (m_active) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        int ext;
        repeat (3) @(negedge clk);
        chk("R1 reset word", rdata, 32'd0);
        chk("R1 reset mdc", 32'(mdc), 32'd0);
        chk("R1 reset oe", 32'(mdio_oe), 32'd0);
        rst_n = 1'b1;
        cmp_on = 1;
        @(negedge clk);

        // write frame, fastest divider
        launch(mk(0, 5'h11, 5'h0A, 16'hA5C3), 8'd0);
        wait_idle();
        chk("R3 write frame length", 32'(last_len), 32'(128 * 1));
        chk("R6 oe released after write", 32'(mdio_oe), 32'd0);

        // read frame, divider 2, with a write and divider change mid-frame
        phy_val = 16'h3C96;
        launch(mk(1, 5'h1F, 5'h00, 16'h0000), 8'd2);
        repeat (100) @(negedge clk);
        drv_wr = 1'b1; drv_wdata = mk(0, 5'h03, 5'h07, 16'hFFFF); drv_div = 8'd5;
        @(negedge clk);
        drv_wr = 1'b0;
        chk("R9 phy field after busy write", 32'(rdata[20:16]), 32'h1F);
        wait_idle();
        chk("R10 read frame length", 32'(last_len), 32'(128 * 3));
        chk("R7 read data", 32'(rdata[15:0]), 32'h3C96);
        chk("R8 valid after read", 32'(rdata[27]), 32'd1);

        // write collides with the final edge of a frame
        launch(mk(0, 5'h05, 5'h12, 16'h1234), 8'd0);
        chk("R8 valid cleared on launch", 32'(rdata[27]), 32'd0);
        while (!(m_active && m_t == 128 * m_half - 1)) @(negedge clk);
        drv_wr = 1'b1; drv_wdata = mk(1, 5'h0C, 5'h01, 16'h0000); drv_div = 8'd1;
        phy_val = 16'h8001;
        @(negedge clk);
        chk("R9 end-edge write ignored", 32'(rdata[28]), 32'd0);
        chk("R9 fields kept at end edge", 32'(rdata[20:16]), 32'h05);
        @(negedge clk);
        drv_wr = 1'b0;
        chk("R9 held write accepted", 32'(rdata[20:16]), 32'h0C);
        wait_idle();
        chk("R4 frame length divider 1", 32'(last_len), 32'(128 * 2));
        chk("R7 read data edges", 32'(rdata[15:0]), 32'h8001);

        // write after read clears valid; large divider
        launch(mk(0, 5'h00, 5'h1F, 16'h0F0F), 8'd3);
        chk("R8 valid clear", 32'(rdata[27]), 32'd0);
        wait_idle();
        ext = 128 * 4;
        chk("R3 frame length divider 3", 32'(last_len), 32'(ext));
        chk("R8 no valid after write", 32'(rdata[27]), 32'd0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule